// File: doc/BRIEF.md
# Maintenance Read Request Bridge

This block sits between the request decoder of a serial-protocol logical layer and user logic. Each decoded maintenance request header (transaction type, configuration offset, transaction ID) arrives on a valid/ready input. A read request whose offset lies outside the local register window is issued as a read on a pipelined memory-mapped master port. Every other header goes unchanged to a local-register output: a read aimed at the local window, or any header with another transaction type.

Several reads can be in flight on the master port at once. The bridge keeps the IDs of accepted reads in an in-order queue. Each returning data beat is paired with the oldest ID and sent to the response builder. The upstream port is back-pressured in three cases: when the issue slot is held by waitrequest, when the outstanding queue has no room left, or when a locally routed header meets a busy local consumer.

Back-pressure rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. The header must stay stable while `req_valid` is high and `req_ready` is low. `loc_valid`/`loc_ready` follow the same rule. The response output has no ready input, because the master port's data return cannot be stalled. The response builder must take every `rsp_valid` cycle.

Top module: `mnt_rd_bridge`

## Requirements
- R1: A header with transaction type 4'b0000 and an offset outside [LOC_LO, LOC_HI] is issued on the master port. `mst_read` goes high on the clock after the upstream handshake, and `mst_address` carries the offset.
- R2: A header with any nonzero transaction type, or with an offset inside [LOC_LO, LOC_HI], appears on `loc_valid` with its fields unchanged, and it never causes a master read.
- R3: While `mst_read` and `mst_waitrequest` are both high, `mst_read` and `mst_address` stay unchanged on the next clock.
- R4: A master read counts as accepted only on a clock where `mst_read` is high and `mst_waitrequest` is low. IDs of accepted reads are kept in acceptance order.
- R5: In any cycle with `mst_readdatavalid` high, `rsp_valid` is high in the same cycle. `rsp_data` equals `mst_readdata`, and `rsp_tid` is the ID of the oldest accepted read not yet answered.
- R6: The reads accepted and not yet answered, plus a read waiting in the issue slot, never exceed DEPTH (4). For an external read, `req_ready` is high exactly when the slot is empty or is being accepted this cycle, and fewer than DEPTH reads are counted.
- R7: For a locally routed header, `req_ready` equals `loc_ready`.
- R8: After reset, `mst_read` and `rsp_valid` are low and no reads are outstanding.
- R9: Offsets LOC_LO and LOC_HI are local. LOC_LO-1 and LOC_HI+1 are external.
- R10: With `mst_waitrequest` low and room in the queue, external reads issue on consecutive clocks, for example offsets 0x10, 0x14 and 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decoded header valid |
| req_ready | output | 1 | Header accepted when high with valid |
| req_ttype | input | 4 | Transaction type |
| req_offset | input | OFS_W | Configuration offset |
| req_tid | input | TID_W | Transaction ID |
| loc_valid | output | 1 | Header for local registers valid |
| loc_ready | input | 1 | Local register block can take a header |
| loc_ttype | output | 4 | Forwarded transaction type |
| loc_offset | output | OFS_W | Forwarded offset |
| loc_tid | output | TID_W | Forwarded transaction ID |
| mst_read | output | 1 | Master read strobe |
| mst_address | output | OFS_W | Master read address |
| mst_waitrequest | input | 1 | Master stall from user logic |
| mst_readdatavalid | input | 1 | Read data return strobe |
| mst_readdata | input | DATA_W | Returned read data |
| rsp_valid | output | 1 | Response valid (no back-pressure) |
| rsp_tid | output | TID_W | ID paired with the response |
| rsp_data | output | DATA_W | Response data |

## Verification
A broken ID queue shows at the ports on the first data return after the fault: `rsp_tid` no longer matches the bench's record of acceptance order. A wrong occupancy count shows within the same cycle as a wrong `req_ready` against the bench's count, or, after a few issues, as a read beyond the four-deep limit. A wrong issue-slot state shows on the next clock as a `mst_read` or `mst_address` value that differs from the prediction. That includes a dropped hold under waitrequest and a locally routed header that leaks onto the master port.

// File: rtl/mnt_rd_pkg.sv
package mnt_rd_pkg;
  localparam logic [3:0] TT_MNT_READ = 4'b0000;

  typedef enum logic [1:0] {
    ROUTE_LOCAL = 2'd0,
    ROUTE_EXT   = 2'd1
  } route_e;
endpackage

// File: rtl/mnt_req_route.sv
module mnt_req_route
  import mnt_rd_pkg::*;
#(
  parameter int unsigned OFS_W  = 21,
  parameter logic [OFS_W-1:0] LOC_LO = 21'h10000,
  parameter logic [OFS_W-1:0] LOC_HI = 21'h1FFFF
) (
  input  logic [3:0]       ttype,
  input  logic [OFS_W-1:0] offset,
  output route_e           route
);
  logic in_window;

  always_comb begin
    in_window = (offset >= LOC_LO) && (offset <= LOC_HI);
    if ((ttype == TT_MNT_READ) && !in_window) route = ROUTE_EXT;
    else                                      route = ROUTE_LOCAL;
  end
endmodule

// File: rtl/mnt_rd_issue.sv
module mnt_rd_issue #(
  parameter int unsigned OFS_W = 21,
  parameter int unsigned TID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFS_W-1:0] load_addr,
  input  logic [TID_W-1:0] load_tid,
  input  logic             waitrequest,
  output logic             rd,
  output logic [OFS_W-1:0] addr,
  output logic [TID_W-1:0] slot_tid,
  output logic             can_load,
  output logic             accepted
);
  assign accepted = rd && !waitrequest;
  assign can_load = !rd || !waitrequest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd       <= 1'b0;
      addr     <= '0;
      slot_tid <= '0;
    end else if (can_load) begin
      rd <= load;
      if (load) begin
        addr     <= load_addr;
        slot_tid <= load_tid;
      end
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && waitrequest) |=> (rd && $stable(addr) && $stable(slot_tid)));
endmodule

// File: rtl/mnt_tid_fifo.sv
module mnt_tid_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((count < CW'(DEPTH)) || pop));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/mnt_rd_bridge.sv
module mnt_rd_bridge
  import mnt_rd_pkg::*;
#(
  parameter int unsigned OFS_W  = 21,
  parameter int unsigned TID_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  parameter logic [OFS_W-1:0] LOC_LO = 21'h10000,
  parameter logic [OFS_W-1:0] LOC_HI = 21'h1FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_ttype,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [TID_W-1:0]  req_tid,
  output logic              loc_valid,
  input  logic              loc_ready,
  output logic [3:0]        loc_ttype,
  output logic [OFS_W-1:0]  loc_offset,
  output logic [TID_W-1:0]  loc_tid,
  output logic              mst_read,
  output logic [OFS_W-1:0]  mst_address,
  input  logic              mst_waitrequest,
  input  logic              mst_readdatavalid,
  input  logic [DATA_W-1:0] mst_readdata,
  output logic              rsp_valid,
  output logic [TID_W-1:0]  rsp_tid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  route_e          route;
  logic            is_ext, room, ext_ready, load, can_load, accepted, pop;
  logic [TID_W-1:0] slot_tid, head_tid;
  logic [CW-1:0]   fifo_count;
  logic [CW:0]     in_flight;

  mnt_req_route #(.OFS_W(OFS_W), .LOC_LO(LOC_LO), .LOC_HI(LOC_HI)) u_route (
    .ttype (req_ttype),
    .offset(req_offset),
    .route (route)
  );

  assign is_ext    = (route == ROUTE_EXT);
  assign in_flight = {1'b0, fifo_count} + (CW+1)'(mst_read);
  assign room      = in_flight < (CW+1)'(DEPTH);
  assign ext_ready = can_load && room;
  assign load      = req_valid && is_ext && ext_ready;
  assign req_ready = is_ext ? ext_ready : loc_ready;

  assign loc_valid  = req_valid && !is_ext;
  assign loc_ttype  = req_ttype;
  assign loc_offset = req_offset;
  assign loc_tid    = req_tid;

  mnt_rd_issue #(.OFS_W(OFS_W), .TID_W(TID_W)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_addr  (req_offset),
    .load_tid   (req_tid),
    .waitrequest(mst_waitrequest),
    .rd         (mst_read),
    .addr       (mst_address),
    .slot_tid   (slot_tid),
    .can_load   (can_load),
    .accepted   (accepted)
  );

  assign pop = mst_readdatavalid && (fifo_count != '0);

  mnt_tid_fifo #(.DEPTH(DEPTH), .W(TID_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accepted),
    .push_data(slot_tid),
    .pop      (pop),
    .head     (head_tid),
    .count    (fifo_count)
  );

  assign rsp_valid = pop;
  assign rsp_tid   = head_tid;
  assign rsp_data  = mst_readdata;

  assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight <= (CW+1)'(DEPTH));
  assert_issue_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_read) |-> $past(req_valid && req_ready && (req_ttype == TT_MNT_READ)));
  assert_rsp_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mst_readdatavalid);
endmodule

// File: tb/mnt_rd_bridge_bench.sv
module mnt_rd_bridge_bench;
  localparam int unsigned OFS_W = 21, TID_W = 8, DATA_W = 32, DEPTH = 4;
  localparam logic [OFS_W-1:0] LO = 21'h10000, HI = 21'h1FFFF;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, loc_valid, loc_ready = 0;
  logic [3:0] req_ttype = 0, loc_ttype;
  logic [OFS_W-1:0] req_offset = 0, loc_offset, mst_address;
  logic [TID_W-1:0] req_tid = 0, loc_tid, rsp_tid;
  logic mst_read, mst_waitrequest = 0, mst_readdatavalid = 0, rsp_valid;
  logic [DATA_W-1:0] mst_readdata = 0, rsp_data;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mnt_rd_bridge #(.OFS_W(OFS_W), .TID_W(TID_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
                  .LOC_LO(LO), .LOC_HI(HI)) u_mnt_rd_bridge (.*);

  function automatic bit is_ext(input logic [3:0] tt, input logic [OFS_W-1:0] off);
    return (tt == 4'b0000) && ((off < LO) || (off > HI));
  endfunction

  function automatic logic [DATA_W-1:0] dataf(input logic [OFS_W-1:0] a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [3:0]       dtt  [9] = '{4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0};
  logic [OFS_W-1:0] doff [9] = '{21'h10, 21'h14, 21'h18, 21'h20, 21'h0FFFF,
                                 21'h10000, 21'h1FFFF, 21'h20000, 21'h24};

  initial begin
    int idx = 0, cyc = 0, wait_pct = 0, rdv_pct = 0, loc_pct = 100;
    bit slot = 0, stall_seen = 0, hold = 0;
    logic [OFS_W-1:0] slot_off = 0;
    logic [TID_W-1:0] slot_tid = 0;
    logic [OFS_W-1:0] out_off[$];
    logic [TID_W-1:0] out_tid[$];
    logic [DATA_W-1:0] rdata;
    bit rdv, e, exp_ready, acc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(mst_read == 0, "R8 mst_read", 64'(mst_read), 0);
    chk(rsp_valid == 0, "R8 rsp_valid", 64'(rsp_valid), 0);
    rst_n = 1;
    while (idx < 600 || hold || slot || out_tid.size() > 0) begin
      @(negedge clk);
      cyc++;
      if (cyc == 40) begin wait_pct = 30; rdv_pct = 45; loc_pct = 70; end
      if (idx >= 600) begin wait_pct = 0; rdv_pct = 100; end
      if (!hold && idx < 600) begin
        if (idx < 9) begin req_ttype = dtt[idx]; req_offset = doff[idx]; end
        else begin
          req_ttype = ($urandom % 2) ? 4'h0 : 4'($urandom % 15 + 1);
          req_offset = ($urandom % 4 == 0) ? (LO + 21'($urandom % 21'h10000))
                                           : 21'($urandom) & 21'h1FFFFC;
        end
        req_tid = TID_W'(idx);
        hold = (idx < 9) || ($urandom % 100 < 70);
        if (hold) idx++;
      end
      req_valid = hold;
      mst_waitrequest = ($urandom % 100) < wait_pct;
      loc_ready = ($urandom % 100) < loc_pct;
      rdv = (out_tid.size() > 0) && (($urandom % 100) < rdv_pct);
      rdata = rdv ? dataf(out_off[0]) : DATA_W'($urandom);
      mst_readdatavalid = rdv;
      mst_readdata = rdata;
      #1;
      chk(mst_read == slot, "R1 mst_read", 64'(mst_read), 64'(slot));
      if (slot) chk(mst_address == slot_off, "R1 R3 mst_address", 64'(mst_address), 64'(slot_off));
      exp_ready = 0;
      e = is_ext(req_ttype, req_offset);
      if (hold) begin
        chk(loc_valid == !e, "R2 R9 loc_valid", 64'(loc_valid), 64'(!e));
        if (e) exp_ready = (!slot || !mst_waitrequest) && (out_tid.size() + int'(slot) < DEPTH);
        else exp_ready = loc_ready;
        chk(req_ready == exp_ready, e ? "R6 R10 req_ready" : "R7 req_ready",
            64'(req_ready), 64'(exp_ready));
        if (e && !exp_ready && (out_tid.size() + int'(slot) == DEPTH)) stall_seen = 1;
        if (!e && exp_ready)
          chk(loc_offset == req_offset && loc_tid == req_tid && loc_ttype == req_ttype,
              "R2 loc fields", 64'(loc_offset), 64'(req_offset));
      end else chk(loc_valid == 0, "R2 idle loc_valid", 64'(loc_valid), 0);
      chk(rsp_valid == rdv, "R5 rsp_valid", 64'(rsp_valid), 64'(rdv));
      if (rdv) begin
        chk(rsp_tid == out_tid[0], "R4 R5 rsp_tid", 64'(rsp_tid), 64'(out_tid[0]));
        chk(rsp_data == rdata, "R5 rsp_data", 64'(rsp_data), 64'(rdata));
        void'(out_tid.pop_front()); void'(out_off.pop_front());
      end
      acc = slot && !mst_waitrequest;
      if (acc) begin out_off.push_back(slot_off); out_tid.push_back(slot_tid); slot = 0; end
      if (hold && exp_ready) begin
        if (e) begin slot = 1; slot_off = req_offset; slot_tid = req_tid; end
        hold = 0;
      end
    end
    req_valid = 0;
    chk(stall_seen, "R6 stall at full", 64'(stall_seen), 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule